// File: doc/BRIEF.md
# Reset-Cause and Clock-Enable Register File

This block is the software-visible part of a small reset and clock controller. One register holds four peripheral clock-enable bits and drives one enable line for each peripheral: power interface, I2C1, window watchdog and timer 2. A second register records why the chip last came out of reset. Each cause has a sticky flag that hardware sets from an event pulse. Software reads these flags and clears all of them at once by writing a single remove bit. The same register holds the low-speed oscillator enable and a ready indication. Ready rises a configurable number of cycles after the enable, which stands in for the oscillator's startup time.

Access is through a simple select/write bus with a combinational read path. The block also passes the read data of each peripheral through a gate that returns zero while that peripheral's clock is off. There are two resets. The power-on input clears everything and leaves only the power-on flag set. The system reset clears the enables but keeps the cause flags, so software can inspect them after a reset.

Top module: `rstclk_regs`

## Requirements
- R1: The clock-enable register at offset 0x1C has read/write bits 0, 11, 21 and 28, which drive periph_clk_en[0] (timer 2), [1] (window watchdog), [2] (I2C1) and [3] (power interface). 1 means the clock is on. All of them are 0 after either reset.
- R2: Every other bit of the clock-enable register reads 0, and writing it has no effect.
- R3: Lane i of periph_rdata (bits 32*i+31 down to 32*i) equals lane i of periph_rdata_raw while periph_clk_en[i] is 1, and is 0 while it is 0.
- R4: In the status register at offset 0x24, flags sit at bit 31 (low-power, rst_evt[4]), bit 30 (window watchdog, rst_evt[3]), bit 29 (independent watchdog, rst_evt[2]), bit 28 (software, rst_evt[1]), bit 27 (power-on) and bit 26 (pin, rst_evt[0]). A one-cycle event pulse sets its flag at the next clock edge, and the flag stays set.
- R5: Bus writes to bits 26 to 31 without bit 24 set leave the flags unchanged.
- R6: A write of 1 to bit 24 of the status register clears all six flags. Bit 24 reads back 0, and the status bits 2 to 23 and 25 read 0.
- R7: When an event pulse and a bit-24 clear write fall in the same cycle, the flag of that event is set afterwards and the other flags are cleared.
- R8: sys_rst_n low clears the clock enables and the oscillator enable but leaves the flags unchanged.
- R9: por_n low clears all state and leaves only the power-on flag (bit 27) set.
- R10: Status bit 0 is the oscillator enable (read/write, drives losc_en). Bit 1 (losc_rdy) is read-only and becomes 1 exactly OSC_START_CYC clock edges after the edge that wrote the enable to 1.
- R11: Writing the oscillator enable to 0 makes the ready bit 0 straight after that edge.
- R12: A read at any offset other than 0x1C or 0x24 returns 0, and so does the read data while bus_sel is 0 or bus_wr is 1. A write to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low; flags survive it |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| rst_evt | input | 5 | Reset-cause event pulses: pin, software, independent watchdog, window watchdog, low-power |
| periph_clk_en | output | 4 | Clock enables: timer 2, window watchdog, I2C1, power interface |
| periph_rdata_raw | input | 4*DATA_W | Ungated peripheral read data, one lane per peripheral |
| periph_rdata | output | 4*DATA_W | Read data after gating by the clock enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| losc_rdy | output | 1 | Low-speed oscillator ready |

## Verification
The cause-flag register has two writers in the same cycle: hardware event pulses that set flags and the software remove bit that clears them all. The bench drives a status write with bit 24 set together with a low-power event pulse. It then reads back that only bit 31 survived, and follows with a plain clear to show that the other flags do go. A second overlap is the system reset arriving with flags set. The bench checks that the enables return to zero while the flag word reads back unchanged.

// File: rtl/rstclk_pkg.sv
package rstclk_pkg;
   localparam int PERIPH_N = 4;
   localparam int FLAG_N   = 6;
   localparam int EVT_N    = 5;

   localparam logic [7:0] OFS_CLKEN = 8'h1C;
   localparam logic [7:0] OFS_STAT  = 8'h24;

   // peripheral order: timer 2, window watchdog, I2C1, power interface
   localparam int CLKEN_POS [PERIPH_N] = '{0, 11, 21, 28};

   localparam int STAT_OSC_EN   = 0;
   localparam int STAT_OSC_RDY  = 1;
   localparam int STAT_CLR      = 24;
   localparam int STAT_FLAG_LSB = 26;

   // flag index: 0 pin, 1 power-on, 2 software, 3 iwdg, 4 wwdg, 5 low-power
   localparam logic [FLAG_N-1:0] FLAG_POR_ONLY = 6'b000010;

   function automatic logic [FLAG_N-1:0] evt_to_flags(input logic [EVT_N-1:0] e);
      return {e[4], e[3], e[2], e[1], 1'b0, e[0]};
   endfunction
endpackage

// File: rtl/rstclk_clken_reg.sv
module rstclk_clken_reg
   import rstclk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [PERIPH_N-1:0] en
);
   for (genvar g = 0; g < PERIPH_N; g++) begin : g_bit
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)  en[g] <= 1'b0;
         else if (wr)  en[g] <= wdata[CLKEN_POS[g]];
      end
   end
endmodule

// File: rtl/rstclk_flag_reg.sv
module rstclk_flag_reg
   import rstclk_pkg::*;
(
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr,
   input  logic [FLAG_N-1:0] ev,
   output logic [FLAG_N-1:0] flags
);
   logic [FLAG_N-1:0] kept;

   assign kept = clr ? '0 : flags;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) flags <= FLAG_POR_ONLY;
      else        flags <= kept | ev;
   end
endmodule

// File: rtl/rstclk_losc_ctl.sv
module rstclk_losc_ctl #(
   parameter int OSC_START_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic wr,
   input  logic wr_val,
   output logic en,
   output logic rdy
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  en <= 1'b0;
      else if (wr)  en <= wr_val;
   end

   if (OSC_START_CYC == 0) begin : g_instant
      assign rdy = en;
   end else begin : g_count
      localparam int CNT_W = $clog2(OSC_START_CYC + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(OSC_START_CYC - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             done_q;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else if (!en) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
         end
      end

      assign rdy = en & done_q;
   end
endmodule

// File: rtl/rstclk_rd_gate.sv
module rstclk_rd_gate
   import rstclk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [PERIPH_N-1:0]        en,
   input  logic [PERIPH_N*DATA_W-1:0] raw,
   output logic [PERIPH_N*DATA_W-1:0] gated
);
   for (genvar g = 0; g < PERIPH_N; g++) begin : g_lane
      assign gated[g*DATA_W +: DATA_W] = en[g] ? raw[g*DATA_W +: DATA_W] : '0;
   end
endmodule

// File: rtl/rstclk_regs.sv
module rstclk_regs
   import rstclk_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int OSC_START_CYC = 16
) (
   input  logic                       clk,
   input  logic                       por_n,
   input  logic                       sys_rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [EVT_N-1:0]           rst_evt,
   output logic [PERIPH_N-1:0]        periph_clk_en,
   input  logic [PERIPH_N*DATA_W-1:0] periph_rdata_raw,
   output logic [PERIPH_N*DATA_W-1:0] periph_rdata,
   output logic                       losc_en,
   output logic                       losc_rdy
);
   if (DATA_W != 32) begin : g_bad_dw
      $error("rstclk_regs: DATA_W must be 32");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("rstclk_regs: ADDR_W must be at least 6");
   end
   if (OSC_START_CYC < 0) begin : g_bad_osc
      $error("rstclk_regs: OSC_START_CYC must not be negative");
   end

   localparam logic [ADDR_W-1:0] A_CLKEN = ADDR_W'(OFS_CLKEN);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

   logic              arst_n;
   logic              hit_clken, hit_stat;
   logic              wr_clken, wr_stat, rd_en;
   logic [FLAG_N-1:0] flag_q;
   logic [DATA_W-1:0] clken_word, stat_word;

   assign arst_n    = por_n & sys_rst_n;
   assign hit_clken = (bus_addr == A_CLKEN);
   assign hit_stat  = (bus_addr == A_STAT);
   assign wr_clken  = bus_sel & bus_wr & hit_clken;
   assign wr_stat   = bus_sel & bus_wr & hit_stat;
   assign rd_en     = bus_sel & ~bus_wr;

   rstclk_clken_reg #(.DATA_W(DATA_W)) u_clken (
      .clk   (clk),
      .arst_n(arst_n),
      .wr    (wr_clken),
      .wdata (bus_wdata),
      .en    (periph_clk_en)
   );

   rstclk_flag_reg u_flags (
      .clk  (clk),
      .por_n(por_n),
      .clr  (wr_stat & bus_wdata[STAT_CLR]),
      .ev   (evt_to_flags(rst_evt)),
      .flags(flag_q)
   );

   rstclk_losc_ctl #(.OSC_START_CYC(OSC_START_CYC)) u_losc (
      .clk   (clk),
      .arst_n(arst_n),
      .wr    (wr_stat),
      .wr_val(bus_wdata[STAT_OSC_EN]),
      .en    (losc_en),
      .rdy   (losc_rdy)
   );

   rstclk_rd_gate #(.DATA_W(DATA_W)) u_gate (
      .en   (periph_clk_en),
      .raw  (periph_rdata_raw),
      .gated(periph_rdata)
   );

   always_comb begin
      clken_word = '0;
      for (int i = 0; i < PERIPH_N; i++) clken_word[CLKEN_POS[i]] = periph_clk_en[i];
   end

   always_comb begin
      stat_word = '0;
      stat_word[STAT_OSC_EN]  = losc_en;
      stat_word[STAT_OSC_RDY] = losc_rdy;
      stat_word[STAT_FLAG_LSB +: FLAG_N] = flag_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en && hit_clken)     bus_rdata = clken_word;
      else if (rd_en && hit_stat) bus_rdata = stat_word;
   end
endmodule

// File: rtl/rstclk_regs_chk.sv
module rstclk_regs_chk
   import rstclk_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int OSC_START_CYC = 16
) (
   input logic                       clk,
   input logic                       por_n,
   input logic                       sys_rst_n,
   input logic                       bus_sel,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [EVT_N-1:0]           rst_evt,
   input logic [FLAG_N-1:0]          flags,
   input logic [PERIPH_N-1:0]        periph_clk_en,
   input logic [PERIPH_N*DATA_W-1:0] periph_rdata,
   input logic                       losc_en,
   input logic                       losc_rdy
);
   localparam logic [DATA_W-1:0] CLKEN_RSVD = ~DATA_W'(32'h1020_0801);

   logic rd_clken, rd_stat, rd_other, clr_wr;
   assign rd_clken = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFS_CLKEN));
   assign rd_stat  = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFS_STAT));
   assign rd_other = ~(rd_clken | rd_stat);
   assign clr_wr   = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_STAT)) & bus_wdata[STAT_CLR];

   AST_CLKEN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rd_clken |-> (bus_rdata & CLKEN_RSVD) == '0); // R2

   for (genvar g = 0; g < PERIPH_N; g++) begin : g_lane
      AST_GATED_LANE_ZERO: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
         !periph_clk_en[g] |-> periph_rdata[g*DATA_W +: DATA_W] == '0); // R3
   end

   for (genvar k = 0; k < EVT_N; k++) begin : g_evt
      localparam int FI = (k == 0) ? 0 : k + 1;
      AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
         rst_evt[k] |=> flags[FI]); // R4 R7
   end

   for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
         (flags[f] && !clr_wr) |=> flags[f]); // R5 R8
   end

   AST_CLR_ALL_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
      (clr_wr && rst_evt == '0) |=> flags == '0); // R6

   AST_CLR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rd_stat |-> !bus_rdata[STAT_CLR]); // R6

   AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      losc_rdy |-> losc_en); // R11

   if (OSC_START_CYC > 0) begin : g_rdy_delay
      AST_RDY_NOT_SAME_EDGE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
         $rose(losc_rdy) |-> $past(losc_en)); // R10
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rd_other |-> bus_rdata == '0); // R12
endmodule

bind rstclk_regs rstclk_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OSC_START_CYC(OSC_START_CYC)
) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .sys_rst_n    (sys_rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .rst_evt      (rst_evt),
   .flags        (flag_q),
   .periph_clk_en(periph_clk_en),
   .periph_rdata (periph_rdata),
   .losc_en      (losc_en),
   .losc_rdy     (losc_rdy)
);

// File: tb/rstclk_regs_tb_top.sv
module rstclk_regs_tb_top;
   localparam int CLK_P = 10;
   localparam int START = 5;
   localparam int AW    = 8;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          por_n, sys_rst_n;
   logic          bus_sel, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic [4:0]    rst_evt;
   logic [3:0]    periph_clk_en;
   logic [4*DW-1:0] raw, gated;
   logic          losc_en, losc_rdy;

   int n_chk = 0;
   int n_bad = 0;
   bit run   = 1'b0;

   // behavioural model state
   logic [3:0] m_en;
   logic       m_osc;
   int         m_cnt;
   logic [5:0] m_flags;

   rstclk_regs #(.ADDR_W(AW), .DATA_W(DW), .OSC_START_CYC(START)) dut_i (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_evt(rst_evt),
      .periph_clk_en(periph_clk_en), .periph_rdata_raw(raw), .periph_rdata(gated),
      .losc_en(losc_en), .losc_rdy(losc_rdy)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read();
      logic [31:0] r = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == 8'h1C) begin
            r[0] = m_en[0]; r[11] = m_en[1]; r[21] = m_en[2]; r[28] = m_en[3];
         end else if (bus_addr == 8'h24) begin
            r[0] = m_osc;
            r[1] = m_osc && (m_cnt >= START);
            r[31:26] = m_flags;
         end
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!por_n) begin
         m_en = '0; m_osc = 1'b0; m_cnt = 0; m_flags = 6'b000010;
      end else begin
         if (!sys_rst_n) begin
            m_en = '0; m_osc = 1'b0; m_cnt = 0;
         end else begin
            if (m_osc) begin
               if (m_cnt < START) m_cnt++;
            end else m_cnt = 0;
            if (bus_sel && bus_wr && bus_addr == 8'h1C)
               m_en = {bus_wdata[28], bus_wdata[21], bus_wdata[11], bus_wdata[0]};
            if (bus_sel && bus_wr && bus_addr == 8'h24)
               m_osc = bus_wdata[0];
         end
         if (bus_sel && bus_wr && bus_addr == 8'h24 && bus_wdata[24]) m_flags = '0;
         m_flags = m_flags | {rst_evt[4], rst_evt[3], rst_evt[2], rst_evt[1], 1'b0, rst_evt[0]};
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (run && por_n && sys_rst_n) begin
         chk(128'(periph_clk_en), 128'(m_en), "R1 clk_en");
         chk(128'(losc_en), 128'(m_osc), "R10 losc_en");
         chk(128'(losc_rdy), 128'(m_osc && m_cnt >= START), "R10 losc_rdy");
         chk(128'(bus_rdata), 128'(m_read()), "R12 rdata");
         for (int i = 0; i < 4; i++)
            chk(128'(gated[i*DW +: DW]), 128'(m_en[i] ? raw[i*DW +: DW] : 32'h0), "R3 lane");
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [4:0] e);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; rst_evt = e;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; rst_evt = '0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      chk(128'(bus_rdata), 128'(exp), tag);
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] e);
      @(posedge clk); #1; rst_evt = e;
      @(posedge clk); #1; rst_evt = '0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      por_n = 1'b0; sys_rst_n = 1'b0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rst_evt = '0;
      raw = {32'hD4D4_0004, 32'hC3C3_0003, 32'hB2B2_0002, 32'hA1A1_0001};
      repeat (3) @(posedge clk);
      #1; por_n = 1'b1; sys_rst_n = 1'b1; run = 1'b1;

      // R9 / R1 reset state
      rd_chk(8'h24, 32'h0800_0000, "R9 reset flags");
      rd_chk(8'h1C, 32'h0, "R1 reset enables");

      // R2 reserved bits
      wr(8'h1C, 32'hFFFF_FFFF, '0);
      rd_chk(8'h1C, 32'h1020_0801, "R2 reserved");
      chk(128'(periph_clk_en), 128'hF, "R1 all on");

      // R1 / R3 partial enable
      wr(8'h1C, 32'h0000_0801, '0);
      @(negedge clk);
      chk(128'(periph_clk_en), 128'h3, "R1 partial");
      chk(128'(gated), {64'h0, 32'hB2B2_0002, 32'hA1A1_0001}, "R3 gating");
      @(posedge clk); #1;

      // R4 events set sticky flags
      pulse(5'b00101);
      repeat (2) @(posedge clk); #1;
      rd_chk(8'h24, 32'h2C00_0000, "R4 sticky");

      // R5 direct flag writes ignored
      wr(8'h24, 32'hFC00_0000, '0);
      rd_chk(8'h24, 32'h2C00_0000, "R5 no direct write");

      // R7 clear and event in the same cycle
      wr(8'h24, 32'h0100_0000, 5'b10000);
      rd_chk(8'h24, 32'h8000_0000, "R7 event wins");

      // R6 plain clear, bit 24 reads 0
      wr(8'h24, 32'h0100_0000, '0);
      rd_chk(8'h24, 32'h0, "R6 clear all");

      // R10 oscillator startup; bit 1 write ignored
      wr(8'h24, 32'h0000_0003, '0);
      repeat (START - 1) @(posedge clk);
      @(negedge clk);
      chk(128'(losc_rdy), 128'h0, "R10 not yet ready");
      @(posedge clk); @(negedge clk);
      chk(128'(losc_rdy), 128'h1, "R10 ready");
      @(posedge clk); #1;
      rd_chk(8'h24, 32'h0000_0003, "R10 status");

      // R11 ready drops with enable
      wr(8'h24, 32'h0, '0);
      @(negedge clk);
      chk(128'(losc_rdy), 128'h0, "R11 ready drop");
      @(posedge clk); #1;

      // R8 system reset keeps flags
      wr(8'h1C, 32'h1020_0801, '0);
      wr(8'h24, 32'h1, '0);
      pulse(5'b01010);
      @(posedge clk); #1; sys_rst_n = 1'b0;
      repeat (2) @(posedge clk); #1; sys_rst_n = 1'b1;
      rd_chk(8'h24, 32'h5000_0000, "R8 flags kept");
      rd_chk(8'h1C, 32'h0, "R8 enables cleared");
      chk(128'(periph_clk_en), 128'h0, "R8 clk_en");

      // R12 unmapped offset
      wr(8'h1C, 32'h0020_0000, '0);
      wr(8'h20, 32'hFFFF_FFFF, '0);
      rd_chk(8'h20, 32'h0, "R12 unmapped read");
      rd_chk(8'h1C, 32'h0020_0000, "R12 no side effect");
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0020_0000;
      @(negedge clk);
      chk(128'(bus_rdata), 128'h0, "R12 rdata during write");
      @(posedge clk); #1; bus_sel = 1'b0; bus_wr = 1'b0;

      // R9 power-on reset
      @(posedge clk); #1; por_n = 1'b0;
      repeat (2) @(posedge clk); #1; por_n = 1'b1;
      rd_chk(8'h24, 32'h0800_0000, "R9 por flag only");
      rd_chk(8'h1C, 32'h0, "R9 enables cleared");

      repeat (3) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule